// File: doc/BRIEF.md
# Switch-Selected Status Display Multiplexer

This block turns a 4-bit mode switch into a choice of what a small front panel shows. The panel has a bank of four LEDs and three 2-bit colour channels: red, green and blue. In the activity views, the LEDs report serial-link traffic and back pressure. The colour channels, each enabled by its own switch bit, report the processor run state, the halt reason, and the command/memory busy state. A data-register view shows fixed bit fields of a supplied 16-bit image word. The byte views pick one of four 16-bit status words and one of its two bytes, then show fields of that byte.

The four status words are selected by the two low mode bits:

| Select | Word |
|---|---|
| 0 | Baud-divider readback. The divider is packed above one zero bit, with the fractional field at the bottom. |
| 1 | Program counter |
| 2 | Display register |
| 3 | Data-register image |

Every output is held in a register with a synchronous reset. A change of mode or status is therefore visible one clock after the edge that samples it.

Top module: `status_display_mux`

## Requirements
- R1: While `rst` is high at a rising edge, all of `led`, `rgb_r`, `rgb_g` and `rgb_b` are 0 after that edge.
- R2: Outputs are registered. Values driven after an edge do not change any output until the next rising edge, and at that edge the outputs take the values computed from them.
- R3: With mode[3:2]=00 the LEDs show {not tx_ok, tx_act, not rx_ok, rx_act} on bits 3..0.
- R4: With mode[3:2]=00, mode[0]=1 and cpu_go=1: rgb_g = {cpu_kern_run, cpu_user}, and rgb_r = 0.
- R5: With mode[3:2]=00, mode[0]=1 and cpu_go=0: rgb_r = halt_code, and rgb_g = 0.
- R6: With mode[3:2]=00 and mode[1]=1: rgb_b = {cmd_busy, not cpu_go}.
- R7: In mode 00xy, a channel whose enable bit is 0 is driven to 0. Green and red use y = mode[0]. Blue uses x = mode[1].
- R8: Mode 0100 shows the data-register image: led = dr_word[15:12], rgb_b = dr_word[9:8], rgb_g = dr_word[5:4], rgb_r = dr_word[1:0].
- R9: Modes 0101, 0110 and 0111 drive every LED and colour output to 0.
- R10: With mode[3]=1, mode[1:0] selects the word: 0 = baud readback, 1 = pc_word, 2 = disp_word, 3 = dr_word.
- R11: With mode[3]=1, mode[2] selects the low byte (0) or the high byte (1). The LEDs show bits 7:4 of that byte, and all three colour channels show bits 1:0 of it.
- R12: The baud readback word is {baud_div[11:0], 1'b0, baud_frac[2:0]}. Its low byte therefore shows baud_div[3:0] on the LEDs and baud_frac[1:0] on the colour channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 4 | Display mode switch |
| tx_ok | input | 1 | Transmit side can accept data |
| tx_act | input | 1 | Transmit activity |
| rx_ok | input | 1 | Receive side can accept data |
| rx_act | input | 1 | Receive activity |
| cpu_go | input | 1 | Processor is running |
| cpu_kern_run | input | 1 | Kernel mode and not waiting |
| cpu_user | input | 1 | User or supervisor mode |
| halt_code | input | 2 | Halt reason while stopped |
| cmd_busy | input | 1 | Remote command access in progress |
| baud_div | input | 12 | Baud divider readback |
| baud_frac | input | 3 | Baud divider fractional part |
| pc_word | input | 16 | Program counter |
| disp_word | input | 16 | Display register |
| dr_word | input | 16 | Data-register image |
| led | output | 4 | LED bank |
| rgb_r | output | 2 | Red channel |
| rgb_g | output | 2 | Green channel |
| rgb_b | output | 2 | Blue channel |

## Verification
The bench drives all four enable combinations of the activity views with every flag high. A design that ignores an enable would light a channel that must stay dark. It steps through the three unused modes above the data-register view; a decoder that only matches bit 2 would show the image there. The baud word is packed with every divider and fraction bit set, so a missing or misplaced zero bit moves divider bits into the wrong display fields. A mode change is checked just before the next edge, so a design without the output register shows the new value a cycle early.

// File: rtl/statdisp_pkg.sv
package statdisp_pkg;

   localparam int LED_BITS = 4;
   localparam int CH_BITS  = 2;

   typedef enum logic [1:0] {
      VIEW_ACT  = 2'd0,
      VIEW_DR   = 2'd1,
      VIEW_DARK = 2'd2,
      VIEW_BYTE = 2'd3
   } view_e;

   typedef enum logic [1:0] {
      SRC_BAUD = 2'd0,
      SRC_PC   = 2'd1,
      SRC_DISP = 2'd2,
      SRC_DR   = 2'd3
   } src_e;

   typedef struct packed {
      logic [LED_BITS-1:0] led;
      logic [CH_BITS-1:0]  r;
      logic [CH_BITS-1:0]  g;
      logic [CH_BITS-1:0]  b;
   } panel_t;

   localparam panel_t PANEL_OFF = '0;

   function automatic view_e decode_view(input logic [3:0] m);
      if (m[3])               return VIEW_BYTE;
      else if (!m[2])         return VIEW_ACT;
      else if (m[1:0] == 2'b00) return VIEW_DR;
      else                    return VIEW_DARK;
   endfunction

endpackage

// File: rtl/sd_activity_map.sv
module sd_activity_map
   import statdisp_pkg::*;
(
   input  logic         cpu_en,
   input  logic         bus_en,
   input  logic         tx_ok,
   input  logic         tx_act,
   input  logic         rx_ok,
   input  logic         rx_act,
   input  logic         cpu_go,
   input  logic         cpu_kern_run,
   input  logic         cpu_user,
   input  logic [1:0]   halt_code,
   input  logic         cmd_busy,
   output panel_t       panel
);

   always_comb begin
      panel     = PANEL_OFF;
      panel.led = {~tx_ok, tx_act, ~rx_ok, rx_act};
      if (cpu_en) begin
         if (cpu_go) panel.g = {cpu_kern_run, cpu_user};
         else        panel.r = halt_code;
      end
      if (bus_en) panel.b = {cmd_busy, ~cpu_go};
   end

endmodule

// File: rtl/sd_byte_pick.sv
module sd_byte_pick
   import statdisp_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 12,
   parameter int FRAC_W = 3
) (
   input  src_e               src,
   input  logic               hi_half,
   input  logic [DIV_W-1:0]   baud_div,
   input  logic [FRAC_W-1:0]  baud_frac,
   input  logic [WORD_W-1:0]  pc_word,
   input  logic [WORD_W-1:0]  disp_word,
   input  logic [WORD_W-1:0]  dr_word,
   output logic [7:0]         byte_o
);

   localparam int PAD_W   = WORD_W - DIV_W - FRAC_W;
   localparam int N_SRC   = 4;
   localparam int BYTE_W  = 8;
   localparam int HI_BASE = WORD_W - BYTE_W;

   logic [WORD_W-1:0] baud_word;
   logic [WORD_W-1:0] words [N_SRC];

   generate
      if (PAD_W < 0) begin : g_bad_pack
         $error("sd_byte_pick: divider and fraction exceed the word width");
      end else if (PAD_W == 0) begin : g_pack_tight
         assign baud_word = {baud_div, baud_frac};
      end else begin : g_pack_pad
         assign baud_word = {baud_div, {PAD_W{1'b0}}, baud_frac};
      end
   endgenerate

   assign words[SRC_BAUD] = baud_word;
   assign words[SRC_PC]   = pc_word;
   assign words[SRC_DISP] = disp_word;
   assign words[SRC_DR]   = dr_word;

   logic [WORD_W-1:0] sel_word;
   always_comb sel_word = words[src];

   always_comb begin
      if (hi_half) byte_o = sel_word[HI_BASE +: BYTE_W];
      else         byte_o = sel_word[0 +: BYTE_W];
   end

endmodule

// File: rtl/sd_out_reg.sv
module sd_out_reg
   import statdisp_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  panel_t d,
   output panel_t q
);

   always_ff @(posedge clk) begin
      if (rst) q <= PANEL_OFF;
      else     q <= d;
   end

endmodule

// File: rtl/status_display_mux.sv
module status_display_mux
   import statdisp_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 12,
   parameter int FRAC_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        mode,
   input  logic              tx_ok,
   input  logic              tx_act,
   input  logic              rx_ok,
   input  logic              rx_act,
   input  logic              cpu_go,
   input  logic              cpu_kern_run,
   input  logic              cpu_user,
   input  logic [1:0]        halt_code,
   input  logic              cmd_busy,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic [FRAC_W-1:0] baud_frac,
   input  logic [WORD_W-1:0] pc_word,
   input  logic [WORD_W-1:0] disp_word,
   input  logic [WORD_W-1:0] dr_word,
   output logic [3:0]        led,
   output logic [1:0]        rgb_r,
   output logic [1:0]        rgb_g,
   output logic [1:0]        rgb_b
);

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("status_display_mux: the image view needs 16-bit words");
      end
      if (DIV_W + FRAC_W > WORD_W) begin : g_bad_baud
         $error("status_display_mux: baud fields do not fit the word");
      end
   endgenerate

   view_e  view;
   panel_t act_panel, dr_panel, byte_panel, next_panel, cur_panel;
   logic [7:0] picked;

   always_comb view = decode_view(mode);

   sd_activity_map u_act (
      .cpu_en       (mode[0]),
      .bus_en       (mode[1]),
      .tx_ok        (tx_ok),
      .tx_act       (tx_act),
      .rx_ok        (rx_ok),
      .rx_act       (rx_act),
      .cpu_go       (cpu_go),
      .cpu_kern_run (cpu_kern_run),
      .cpu_user     (cpu_user),
      .halt_code    (halt_code),
      .cmd_busy     (cmd_busy),
      .panel        (act_panel)
   );

   sd_byte_pick #(
      .WORD_W (WORD_W),
      .DIV_W  (DIV_W),
      .FRAC_W (FRAC_W)
   ) u_pick (
      .src       (src_e'(mode[1:0])),
      .hi_half   (mode[2]),
      .baud_div  (baud_div),
      .baud_frac (baud_frac),
      .pc_word   (pc_word),
      .disp_word (disp_word),
      .dr_word   (dr_word),
      .byte_o    (picked)
   );

   always_comb begin
      dr_panel.led = dr_word[15:12];
      dr_panel.b   = dr_word[9:8];
      dr_panel.g   = dr_word[5:4];
      dr_panel.r   = dr_word[1:0];
   end

   always_comb begin
      byte_panel.led = picked[7:4];
      byte_panel.r   = picked[1:0];
      byte_panel.g   = picked[1:0];
      byte_panel.b   = picked[1:0];
   end

   always_comb begin
      unique case (view)
         VIEW_ACT:  next_panel = act_panel;
         VIEW_DR:   next_panel = dr_panel;
         VIEW_BYTE: next_panel = byte_panel;
         default:   next_panel = PANEL_OFF;
      endcase
   end

   sd_out_reg u_reg (
      .clk (clk),
      .rst (rst),
      .d   (next_panel),
      .q   (cur_panel)
   );

   assign led   = cur_panel.led;
   assign rgb_r = cur_panel.r;
   assign rgb_g = cur_panel.g;
   assign rgb_b = cur_panel.b;

   // R1: reset clears the panel
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (led == 4'd0 && rgb_r == 2'd0 && rgb_g == 2'd0 && rgb_b == 2'd0));

   // R3: activity LEDs follow the link flags one cycle later
   p_io_leds_r3: assert property (@(posedge clk) disable iff (rst)
      (mode[3:2] == 2'b00) |=>
      (led == {~$past(tx_ok), $past(tx_act), ~$past(rx_ok), $past(rx_act)}));

   // R7: disabled processor channels stay dark
   p_cpu_dark_r7: assert property (@(posedge clk) disable iff (rst)
      (mode[3:2] == 2'b00 && !mode[0]) |=> (rgb_r == 2'd0 && rgb_g == 2'd0));

   // R7: disabled bus channel stays dark
   p_bus_dark_r7: assert property (@(posedge clk) disable iff (rst)
      (mode[3:2] == 2'b00 && !mode[1]) |=> (rgb_b == 2'd0));

   // R4: red is dark while the processor runs
   p_red_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (mode[3:2] == 2'b00 && cpu_go) |=> (rgb_r == 2'd0));

   // R9: unused modes blank everything
   p_dark_modes_r9: assert property (@(posedge clk) disable iff (rst)
      (mode[3:2] == 2'b01 && mode[1:0] != 2'b00) |=>
      (led == 4'd0 && rgb_r == 2'd0 && rgb_g == 2'd0 && rgb_b == 2'd0));

   // R11: byte views drive identical colour channels
   p_rgb_same_r11: assert property (@(posedge clk) disable iff (rst)
      mode[3] |=> (rgb_r == rgb_g && rgb_g == rgb_b));

endmodule

// File: tb/status_display_mux_test.sv
module status_display_mux_test;

   logic        clk = 1'b0;
   logic        rst;
   logic [3:0]  mode;
   logic        tx_ok, tx_act, rx_ok, rx_act;
   logic        cpu_go, cpu_kern_run, cpu_user;
   logic [1:0]  halt_code;
   logic        cmd_busy;
   logic [11:0] baud_div;
   logic [2:0]  baud_frac;
   logic [15:0] pc_word, disp_word, dr_word;
   logic [3:0]  led;
   logic [1:0]  rgb_r, rgb_g, rgb_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   status_display_mux uut (
      .clk (clk), .rst (rst), .mode (mode),
      .tx_ok (tx_ok), .tx_act (tx_act), .rx_ok (rx_ok), .rx_act (rx_act),
      .cpu_go (cpu_go), .cpu_kern_run (cpu_kern_run), .cpu_user (cpu_user),
      .halt_code (halt_code), .cmd_busy (cmd_busy),
      .baud_div (baud_div), .baud_frac (baud_frac),
      .pc_word (pc_word), .disp_word (disp_word), .dr_word (dr_word),
      .led (led), .rgb_r (rgb_r), .rgb_g (rgb_g), .rgb_b (rgb_b)
   );

   // expected {led, r, g, b} from the current inputs
   function automatic logic [9:0] model_now();
      logic [15:0] w;
      logic [7:0]  by;
      logic [3:0]  l;
      logic [1:0]  r, g, b;
      l = 4'd0; r = 2'd0; g = 2'd0; b = 2'd0;
      if (mode[3]) begin
         case (mode[1:0])
            2'd0:    w = {baud_div, 1'b0, baud_frac};
            2'd1:    w = pc_word;
            2'd2:    w = disp_word;
            default: w = dr_word;
         endcase
         by = mode[2] ? w[15:8] : w[7:0];
         l = by[7:4]; r = by[1:0]; g = by[1:0]; b = by[1:0];
      end else if (!mode[2]) begin
         l = {~tx_ok, tx_act, ~rx_ok, rx_act};
         if (mode[0]) begin
            if (cpu_go) g = {cpu_kern_run, cpu_user};
            else        r = halt_code;
         end
         if (mode[1]) b = {cmd_busy, ~cpu_go};
      end else if (mode[1:0] == 2'b00) begin
         l = dr_word[15:12]; b = dr_word[9:8]; g = dr_word[5:4]; r = dr_word[1:0];
      end
      return {l, r, g, b};
   endfunction

   function automatic string tag_for(input logic [3:0] m);
      if (m[3] && m[1:0] == 2'b00) return "R12 R10 R11";
      if (m[3])                    return "R10 R11";
      if (m[2] && m[1:0] == 2'b00) return "R8";
      if (m[2])                    return "R9";
      return "R3 R4 R5 R6 R7";
   endfunction

   task automatic check(input string tag, input logic [9:0] exp);
      logic [9:0] act;
      act = {led, rgb_r, rgb_g, rgb_b};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s mode=%b actual=%h expected=%h", tag, mode, act, exp);
      end
   endtask

   task automatic rand_flags();
      tx_ok = 1'($urandom); tx_act = 1'($urandom);
      rx_ok = 1'($urandom); rx_act = 1'($urandom);
      cpu_go = 1'($urandom); cpu_kern_run = 1'($urandom);
      cpu_user = 1'($urandom); halt_code = 2'($urandom);
      cmd_busy = 1'($urandom);
      baud_div = 12'($urandom); baud_frac = 3'($urandom);
      pc_word = 16'($urandom); disp_word = 16'($urandom);
      dr_word = 16'($urandom);
   endtask

   task automatic all_high();
      tx_ok = 1; tx_act = 1; rx_ok = 1; rx_act = 1;
      cpu_kern_run = 1; cpu_user = 1; halt_code = 2'b11; cmd_busy = 1;
      baud_div = 12'hfff; baud_frac = 3'h7;
      pc_word = 16'hffff; disp_word = 16'hffff; dr_word = 16'hffff;
   endtask

   // drive at a falling edge, check one full cycle later
   task automatic step(input logic [3:0] m, input string tag);
      logic [9:0] exp;
      @(negedge clk);
      mode = m;
      exp = model_now();
      @(negedge clk);
      check(tag, exp);
   endtask

   initial begin
      logic [9:0] prev;
      void'($urandom(32'd20240611));
      rst = 1'b1; mode = 4'd0;
      all_high(); cpu_go = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", 10'd0);
      rst = 1'b0;

      // R7: every enable combination with all flags high, both run states
      for (int go = 0; go < 2; go++) begin
         for (int m = 0; m < 4; m++) begin
            @(negedge clk); cpu_go = 1'(go);
            step(4'(m), "R7 R4 R5 R6 enables");
         end
      end

      // R9: unused modes with everything high
      for (int m = 5; m < 8; m++) step(4'(m), "R9 dark");
      // R8: image view
      dr_word = 16'b1010_0001_0010_0011;
      step(4'b0100, "R8 image");

      // R12: baud packing with all ones
      baud_div = 12'hfff; baud_frac = 3'h7;
      step(4'b1000, "R12 low byte");
      baud_div = 12'h5a3; baud_frac = 3'h5;
      step(4'b1000, "R12 low byte pattern");
      step(4'b1100, "R12 high byte pattern");

      // R2: new mode must not appear before the next edge
      pc_word = 16'h12f4;
      step(4'b1001, "R2 settle");
      prev = model_now();
      @(negedge clk);
      mode = 4'b1101;
      #5;
      check("R2 hold before edge", prev);
      @(negedge clk);
      check("R2 update after edge", model_now());

      // R1: reset mid-run clears lit outputs
      step(4'b1101, "R11 before reset");
      @(negedge clk); rst = 1'b1;
      @(negedge clk); check("R1 mid reset", 10'd0);
      rst = 1'b0;

      // random sweep
      for (int i = 0; i < 1500; i++) begin
         logic [3:0] m;
         @(negedge clk);
         rand_flags();
         m = 4'($urandom);
         step(m, tag_for(m));
      end

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule